// File: doc/BRIEF.md
# Banked Memory Configuration Register File

This block is the byte-wide control register bank that a processor uses to steer memory banking. It decodes the processor address bus and presents two register windows. The full window holds twelve registers: the live configuration byte, four preset configurations, a mode byte, a RAM-sharing byte, two page-pointer pairs and a fixed identification byte. The full window is decoded only while the I/O-select bit of the configuration register is clear. A short window of five locations is decoded at all times. It gives fast access to the live configuration. Writing one of its preset slots loads the matching preset into the live configuration, and the written data is thrown away.

Each page pointer is a low byte plus a single high bit. A write to a high location only stages that bit. The bit becomes visible when the matching low byte is written, so both halves change in the same cycle. Two outputs follow mode bits 0 and 3. Setting mode bit 6 puts the block into compatibility mode: from then on it is transparent, and only a reset brings it back. Address translation and the memories are handled elsewhere.

Writes are synchronous and take one cycle. Reads are combinational. When the block does not claim a read, the read data port returns the pass-through bus byte unchanged.

Top module: `bank_cfg_regs`

## Requirements
- R1: A read whose address is outside both windows, or outside the decoded range of a window, returns `bus_rd_in` unchanged. A write to such an address changes nothing.
- R2: The full window covers 0xD500..0xD50B. It is decoded only while configuration bit 0 is 0. The register index is address bits 3:0: 0 configuration, 1..4 presets A..D, 5 mode, 6 RAM-sharing, 7/8 page-0 low/high, 9/10 page-1 low/high, 11 identification.
- R3: While mode bit 6 is 1, every read returns `bus_rd_in` and every write is ignored, in both windows.
- R4: The configuration register keeps write bits 6:0. A read of it in either window returns bit 7 as 1.
- R5: The short window covers 0xFF00..0xFF04 and is always decoded. A write at offset 0 loads the configuration register. A write at offset k (1..4) copies preset k into the configuration register and discards the data. A read at offset k returns preset k.
- R6: Preset registers keep write bits 6:0 and read bit 7 as 0. The RAM-sharing register keeps only bits 6 and 3:0 (mask 0x4F).
- R7: A write to a page high location (index 8 or 10) stages only data bit 0. The visible high bit, which reads as 0x00 or 0x01, takes the staged value only when the matching low byte (index 7 or 9) is written.
- R8: A mode read returns the stored byte with bits 2:1 forced to 1. Bit 4 is ANDed with `strap_a_i`, bit 5 with `strap_b_i` and bit 7 with `strap_c_i`.
- R9: The identification location always reads 0x20. Writes to it have no effect.
- R10: Reset clears every register and both staged high bits, and sets the page-1 low pointer to 0x01.
- R11: `cpu_sel_o` equals stored mode bit 0 and `fast_dir_o` equals stored mode bit 3. Both are 0 from reset and change only in the cycle after a mode write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 16 | Processor address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd_in | input | 8 | Bus byte passed through when the block does not claim the read |
| bus_rdata | output | 8 | Read data, combinational |
| strap_a_i | input | 1 | Sense line ANDed into mode bit 4 on read |
| strap_b_i | input | 1 | Sense line ANDed into mode bit 5 on read |
| strap_c_i | input | 1 | Sense line ANDed into mode bit 7 on read |
| cpu_sel_o | output | 1 | Follows mode bit 0 |
| fast_dir_o | output | 1 | Follows mode bit 3 |

## Verification
The assertions check several properties on every cycle:
- unclaimed reads pass through, and the I/O-select bit gates the full window;
- compatibility mode blocks decoding and freezes the state;
- a configuration read always shows bit 7 set, and the identification byte is fixed;
- a short-window preset write copies the right preset;
- a staged high bit stays hidden until its low byte is written;
- the two mode outputs hold steady in cycles without a write.

Only the bench scenarios show the following:
- the exact stored masks;
- the composition of a mode read from the straps;
- that a write to an ungated or frozen location leaves the state unchanged when it is read back;
- the reset values.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

    typedef logic [7:0] byte_t;

    localparam int N_PRESET    = 4;
    localparam int FULL_COUNT  = 12;
    localparam int SHORT_COUNT = N_PRESET + 1;

    localparam logic [3:0] IDX_CFG  = 4'd0;
    localparam logic [3:0] IDX_PRE0 = 4'd1;
    localparam logic [3:0] IDX_MODE = 4'd5;
    localparam logic [3:0] IDX_RAM  = 4'd6;
    localparam logic [3:0] IDX_P0L  = 4'd7;
    localparam logic [3:0] IDX_P0H  = 4'd8;
    localparam logic [3:0] IDX_P1L  = 4'd9;
    localparam logic [3:0] IDX_P1H  = 4'd10;
    localparam logic [3:0] IDX_ID   = 4'd11;

    localparam byte_t RAM_MASK = 8'h4F;
    localparam byte_t ID_VALUE = 8'h20;
    localparam byte_t P1_RESET = 8'h01;

    typedef struct packed {
        logic [6:0]                  cfg;
        logic [N_PRESET-1:0][6:0]    preset;
        byte_t                       mode;
        byte_t                       ramcfg;
        byte_t                       p0_lo;
        logic                        p0_hi;
        logic                        p0_stage;
        byte_t                       p1_lo;
        logic                        p1_hi;
        logic                        p1_stage;
    } bank_state_t;

    function automatic bank_state_t reset_state();
        bank_state_t s;
        s       = '0;
        s.p1_lo = P1_RESET;
        return s;
    endfunction

endpackage

// File: rtl/bcr_decode.sv
module bcr_decode
    import bcr_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] FULL_BASE  = 16'hD500,
    parameter logic [ADDR_W-1:0] SHORT_BASE = 16'hFF00
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              io_off,
    input  logic              compat,
    output logic              full_hit,
    output logic              short_hit,
    output logic [3:0]        idx
);
    localparam logic [ADDR_W-1:0] FULL_LEN  = ADDR_W'(FULL_COUNT);
    localparam logic [ADDR_W-1:0] SHORT_LEN = ADDR_W'(SHORT_COUNT);

    logic [ADDR_W-1:0] full_off;
    logic [ADDR_W-1:0] short_off;
    logic              full_in;
    logic              short_in;

    always_comb begin
        full_off  = addr - FULL_BASE;
        short_off = addr - SHORT_BASE;
        full_in   = (full_off < FULL_LEN);
        short_in  = (short_off < SHORT_LEN);
        full_hit  = full_in && !io_off && !compat;
        short_hit = short_in && !compat;
        idx       = short_in ? short_off[3:0] : full_off[3:0];
    end
endmodule

// File: rtl/bcr_state.sv
module bcr_state
    import bcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_full,
    input  logic        wr_short,
    input  logic [3:0]  idx,
    input  byte_t       wdata,
    output bank_state_t st_q
);
    bank_state_t st_d;

    always_comb begin
        st_d = st_q;
        if (wr_short) begin
            if (idx == IDX_CFG) begin
                st_d.cfg = wdata[6:0];
            end else begin
                for (int k = 0; k < N_PRESET; k++) begin
                    if (idx == IDX_PRE0 + 4'(k)) st_d.cfg = st_q.preset[k];
                end
            end
        end else if (wr_full) begin
            case (idx)
                IDX_CFG:  st_d.cfg = wdata[6:0];
                IDX_MODE: st_d.mode = wdata;
                IDX_RAM:  st_d.ramcfg = wdata & RAM_MASK;
                IDX_P0L: begin
                    st_d.p0_lo = wdata;
                    st_d.p0_hi = st_q.p0_stage;
                end
                IDX_P0H:  st_d.p0_stage = wdata[0];
                IDX_P1L: begin
                    st_d.p1_lo = wdata;
                    st_d.p1_hi = st_q.p1_stage;
                end
                IDX_P1H:  st_d.p1_stage = wdata[0];
                IDX_ID:   st_d = st_q;
                default: begin
                    for (int k = 0; k < N_PRESET; k++) begin
                        if (idx == IDX_PRE0 + 4'(k)) st_d.preset[k] = wdata[6:0];
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= reset_state();
        else        st_q <= st_d;
    end
endmodule

// File: rtl/bcr_rdmux.sv
module bcr_rdmux
    import bcr_pkg::*;
(
    input  logic                     full_hit,
    input  logic                     short_hit,
    input  logic [3:0]               idx,
    input  logic [6:0]               cfg,
    input  logic [N_PRESET-1:0][6:0] preset,
    input  byte_t                    mode,
    input  byte_t                    ramcfg,
    input  byte_t                    p0_lo,
    input  logic                     p0_hi,
    input  byte_t                    p1_lo,
    input  logic                     p1_hi,
    input  logic                     strap_a,
    input  logic                     strap_b,
    input  logic                     strap_c,
    input  byte_t                    pass_in,
    output byte_t                    rdata
);
    byte_t mode_view;
    byte_t preset_view;

    always_comb begin
        mode_view    = mode | 8'h06;
        mode_view[4] = mode[4] & strap_a;
        mode_view[5] = mode[5] & strap_b;
        mode_view[7] = mode[7] & strap_c;

        preset_view = '0;
        for (int k = 0; k < N_PRESET; k++) begin
            if (idx == IDX_PRE0 + 4'(k)) preset_view = {1'b0, preset[k]};
        end

        rdata = pass_in;
        if (short_hit) begin
            rdata = (idx == IDX_CFG) ? {1'b1, cfg} : preset_view;
        end else if (full_hit) begin
            case (idx)
                IDX_CFG:  rdata = {1'b1, cfg};
                IDX_MODE: rdata = mode_view;
                IDX_RAM:  rdata = ramcfg;
                IDX_P0L:  rdata = p0_lo;
                IDX_P0H:  rdata = {7'd0, p0_hi};
                IDX_P1L:  rdata = p1_lo;
                IDX_P1H:  rdata = {7'd0, p1_hi};
                IDX_ID:   rdata = ID_VALUE;
                default:  rdata = preset_view;
            endcase
        end
    end
endmodule

// File: rtl/bank_cfg_regs.sv
module bank_cfg_regs
    import bcr_pkg::*;
#(
    parameter int                ADDR_W     = 16,
    parameter logic [ADDR_W-1:0] FULL_BASE  = 16'hD500,
    parameter logic [ADDR_W-1:0] SHORT_BASE = 16'hFF00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_we,
    input  logic [7:0]        bus_rd_in,
    output logic [7:0]        bus_rdata,
    input  logic              strap_a_i,
    input  logic              strap_b_i,
    input  logic              strap_c_i,
    output logic              cpu_sel_o,
    output logic              fast_dir_o
);
    bank_state_t st_q;
    logic        full_hit;
    logic        short_hit;
    logic [3:0]  idx;

    bcr_decode #(
        .ADDR_W    (ADDR_W),
        .FULL_BASE (FULL_BASE),
        .SHORT_BASE(SHORT_BASE)
    ) u_decode (
        .addr     (bus_addr),
        .io_off   (st_q.cfg[0]),
        .compat   (st_q.mode[6]),
        .full_hit (full_hit),
        .short_hit(short_hit),
        .idx      (idx)
    );

    bcr_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_full (bus_we && full_hit),
        .wr_short(bus_we && short_hit),
        .idx     (idx),
        .wdata   (bus_wdata),
        .st_q    (st_q)
    );

    bcr_rdmux u_rdmux (
        .full_hit (full_hit),
        .short_hit(short_hit),
        .idx      (idx),
        .cfg      (st_q.cfg),
        .preset   (st_q.preset),
        .mode     (st_q.mode),
        .ramcfg   (st_q.ramcfg),
        .p0_lo    (st_q.p0_lo),
        .p0_hi    (st_q.p0_hi),
        .p1_lo    (st_q.p1_lo),
        .p1_hi    (st_q.p1_hi),
        .strap_a  (strap_a_i),
        .strap_b  (strap_b_i),
        .strap_c  (strap_c_i),
        .pass_in  (bus_rd_in),
        .rdata    (bus_rdata)
    );

    assign cpu_sel_o  = st_q.mode[0];
    assign fast_dir_o = st_q.mode[3];
endmodule

// File: rtl/bcr_checker.sv
module bcr_checker
    import bcr_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_we,
    input  logic [7:0]  bus_rd_in,
    input  logic [7:0]  bus_rdata,
    input  logic        cpu_sel_o,
    input  logic        fast_dir_o,
    input  logic        full_hit,
    input  logic        short_hit,
    input  logic [3:0]  idx,
    input  bank_state_t st_q
);
    logic [6:0] sel_preset;
    logic       preset_slot;

    always_comb begin
        sel_preset  = '0;
        preset_slot = 1'b0;
        for (int k = 0; k < N_PRESET; k++) begin
            if (idx == IDX_PRE0 + 4'(k)) begin
                sel_preset  = st_q.preset[k];
                preset_slot = 1'b1;
            end
        end
    end

    a_r1_unclaimed_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_hit && !short_hit) |-> (bus_rdata == bus_rd_in));

    a_r2_io_gate: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg[0] |-> !full_hit);

    a_r3_compat_no_decode: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode[6] |-> (!full_hit && !short_hit));

    a_r3_compat_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.mode[6] |=> $stable(st_q));

    a_r4_cfg_msb: assert property (@(posedge clk) disable iff (!rst_n)
        ((full_hit || short_hit) && idx == IDX_CFG) |-> bus_rdata[7]);

    a_r5_short_copy: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && short_hit && preset_slot) |=> (st_q.cfg == $past(sel_preset)));

    a_r7_p0_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && full_hit && idx == IDX_P0L) |=> $stable(st_q.p0_hi));

    a_r7_p1_commit: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_we && full_hit && idx == IDX_P1L) |=> $stable(st_q.p1_hi));

    a_r9_id_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        (full_hit && idx == IDX_ID) |-> (bus_rdata == ID_VALUE));

    a_r11_outs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> $stable({cpu_sel_o, fast_dir_o}));
endmodule

bind bank_cfg_regs bcr_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_rd_in (bus_rd_in),
    .bus_rdata (bus_rdata),
    .cpu_sel_o (cpu_sel_o),
    .fast_dir_o(fast_dir_o),
    .full_hit  (full_hit),
    .short_hit (short_hit),
    .idx       (idx),
    .st_q      (st_q)
);

// File: tb/bank_cfg_regs_tb.sv
module bank_cfg_regs_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_rd_in = '0;
    logic [7:0]  bus_rdata;
    logic        strap_a_i = 1'b1;
    logic        strap_b_i = 1'b1;
    logic        strap_c_i = 1'b1;
    logic        cpu_sel_o;
    logic        fast_dir_o;

    int checks = 0;
    int failures = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       pending = 1'b0;

    always #10 clk = ~clk;

    bank_cfg_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rd_in(bus_rd_in), .bus_rdata(bus_rdata),
        .strap_a_i(strap_a_i), .strap_b_i(strap_b_i), .strap_c_i(strap_c_i),
        .cpu_sel_o(cpu_sel_o), .fast_dir_o(fast_dir_o)
    );

    // monitor: pops expected read values and compares them mid-cycle
    always @(negedge clk) begin
        if (pending) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            checks++;
            if (bus_rdata !== e) begin
                failures++;
                $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
            end
            pending = 1'b0;
        end
    end

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(posedge clk); #1;
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [15:0] a, input logic [7:0] pass, input logic [7:0] e, input string t);
        @(posedge clk); #1;
        bus_addr = a; bus_we = 1'b0; bus_rd_in = pass;
        exp_q.push_back(e);
        tag_q.push_back(t);
        pending = 1'b1;
        @(negedge clk); #1;
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] e, input string t);
        checks++;
        if (act !== e) begin
            failures++;
            $display("FAIL %s: actual=%02h expected=%02h", t, act, e);
        end
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R10 reset state
        rd(16'hFF00, 8'h11, 8'h80, "R10 cfg reset");
        rd(16'hD509, 8'h11, 8'h01, "R10 page1 low reset");
        rd(16'hD507, 8'h11, 8'h00, "R10 page0 low reset");
        chk({7'd0, cpu_sel_o}, 8'h00, "R10 cpu_sel reset");
        chk({7'd0, fast_dir_o}, 8'h00, "R10 fast_dir reset");

        // R1 pass-through outside windows
        rd(16'h1234, 8'h5A, 8'h5A, "R1 low memory");
        rd(16'hD50C, 8'h33, 8'h33, "R1 past full window");
        rd(16'hFF05, 8'hC3, 8'hC3, "R1 past short window");
        wr(16'hD50D, 8'hFF);
        rd(16'hFF00, 8'h00, 8'h80, "R1 stray write no effect");

        // R4 configuration masking
        wr(16'hFF00, 8'hFE);
        rd(16'hFF00, 8'h00, 8'hFE, "R4 short cfg read");
        rd(16'hD500, 8'h00, 8'hFE, "R4 full cfg read");
        wr(16'hD500, 8'h00);
        rd(16'hD500, 8'h00, 8'h80, "R4 cfg msb forced");

        // R6 presets and RAM sharing
        wr(16'hD501, 8'hFF);
        wr(16'hD502, 8'h12);
        wr(16'hD503, 8'h34);
        wr(16'hD504, 8'h56);
        rd(16'hD501, 8'h00, 8'h7F, "R6 preset A masked");
        rd(16'hD504, 8'h00, 8'h56, "R6 preset D");
        wr(16'hD506, 8'hFF);
        rd(16'hD506, 8'h00, 8'h4F, "R6 ram mask");

        // R5 short window copy
        wr(16'hFF02, 8'hAA);
        rd(16'hFF00, 8'h00, 8'h92, "R5 copy preset B");
        rd(16'hFF03, 8'h00, 8'h34, "R5 short preset read");
        wr(16'hFF01, 8'h00);
        rd(16'hFF00, 8'h00, 8'hFF, "R5 copy preset A");

        // R2 full window gated by cfg bit 0
        rd(16'hD500, 8'h44, 8'h44, "R2 gated read passes");
        wr(16'hD501, 8'h00);
        wr(16'hFF00, 8'h00);
        rd(16'hD501, 8'h00, 8'h7F, "R2 gated write ignored");

        // R8 mode read composition, R11 outputs
        rd(16'hD505, 8'h00, 8'h06, "R8 mode reset view");
        wr(16'hD505, 8'hB9);
        rd(16'hD505, 8'h00, 8'hBF, "R8 straps high");
        chk({7'd0, cpu_sel_o}, 8'h01, "R11 cpu_sel set");
        chk({7'd0, fast_dir_o}, 8'h01, "R11 fast_dir set");
        strap_a_i = 1'b0; strap_c_i = 1'b0;
        rd(16'hD505, 8'h00, 8'h2F, "R8 straps a,c low");
        strap_a_i = 1'b1; strap_b_i = 1'b0; strap_c_i = 1'b1;
        rd(16'hD505, 8'h00, 8'h9F, "R8 strap b low");
        strap_b_i = 1'b1;
        wr(16'hD505, 8'h08);
        chk({7'd0, cpu_sel_o}, 8'h00, "R11 cpu_sel cleared");
        chk({7'd0, fast_dir_o}, 8'h01, "R11 fast_dir kept");

        // R9 identification
        rd(16'hD50B, 8'h00, 8'h20, "R9 id value");
        wr(16'hD50B, 8'h77);
        rd(16'hD50B, 8'h00, 8'h20, "R9 id write ignored");

        // R7 page pointer staging
        wr(16'hD508, 8'hFF);
        rd(16'hD508, 8'h00, 8'h00, "R7 p0 high staged only");
        wr(16'hD507, 8'h40);
        rd(16'hD508, 8'h00, 8'h01, "R7 p0 high committed");
        rd(16'hD507, 8'h00, 8'h40, "R7 p0 low");
        wr(16'hD50A, 8'h03);
        wr(16'hD509, 8'h22);
        rd(16'hD50A, 8'h00, 8'h01, "R7 p1 high committed");
        wr(16'hD50A, 8'h00);
        rd(16'hD50A, 8'h00, 8'h01, "R7 p1 high still old");
        wr(16'hD509, 8'h23);
        rd(16'hD50A, 8'h00, 8'h00, "R7 p1 high cleared");

        // R3 compatibility mode
        wr(16'hD505, 8'h41);
        chk({7'd0, cpu_sel_o}, 8'h01, "R11 cpu_sel in compat");
        rd(16'hFF00, 8'h5C, 8'h5C, "R3 short read passes");
        rd(16'hD505, 8'hA5, 8'hA5, "R3 full read passes");
        wr(16'hD505, 8'h08);
        chk({7'd0, cpu_sel_o}, 8'h01, "R3 mode write ignored");
        chk({7'd0, fast_dir_o}, 8'h00, "R3 fast_dir unchanged");

        // R10 reset clears staging
        do_reset();
        rd(16'hFF00, 8'h00, 8'h80, "R10 cfg after reset");
        rd(16'hD509, 8'h00, 8'h01, "R10 page1 low after reset");
        wr(16'hD507, 8'h10);
        rd(16'hD508, 8'h00, 8'h00, "R10 staged bit cleared");

        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule